// File: doc/BRIEF.md
# Dynamic Frequency Shift Handshake Controller

This block manages the handshake that lets a system change the processor's external clock frequency while the part is running. A request can come from three places: an external request pin, a stop-clock input, or a software-set request bit. The block waits until the core reports a safe point, meaning it is quiescent with no bus cycle outstanding. It then raises a ready output, which tells the system it may retune the clock. Clock generation itself lies outside the block.

The two pin paths use an explicit handshake. The request pin counts only while its enable bit is set. The stop-clock input is always honoured. Both inputs pass through a synchronizer. Once ready is high it stays high as long as the synchronized request stays high, and it falls after the request drops.

The software path needs no enable. A set strobe arms a pending bit. The controller then counts down a programmable wait interval. When the count reaches zero and the core is quiescent, it pulses ready for one cycle and clears the pending bit by itself. The pin paths win over a pending software request. That request is served once the pin transaction ends.

Top module: `freq_shift_ctrl`

## Requirements
- R1: After reset, `rdy_o` and `sw_pend_o` are 0 and the wait interval register holds the parameter `DEF_WAIT` (default 4).
- R2: With `hw_en_i`=1, `quiet_i`=1 and the controller idle, raising `hw_req_i` makes `rdy_o` go high exactly `SYNC_STAGES`+2 clock edges later (4 with the default of 2 stages).
- R3: `rdy_o` never rises unless `quiet_i` was 1 on the previous edge. While a pin request waits with `quiet_i`=0, `rdy_o` stays 0. It rises one edge after `quiet_i` returns to 1.
- R4: Once `rdy_o` is high on a pin path, it stays high while the request is held. It falls exactly `SYNC_STAGES`+1 edges after the request input drops (3 by default).
- R5: While `hw_en_i`=0, `hw_req_i` is ignored. `rdy_o` stays 0 and no software request is created.
- R6: `stpclk_i` acts as a pin request whatever the value of `hw_en_i`, with the same timing as R2 and R4.
- R7: A one-cycle `sw_set_i` pulse sets `sw_pend_o` on the next edge. With wait value W and `quiet_i`=1, `rdy_o` is high for exactly one cycle, W+3 edges after the strobe.
- R8: `sw_pend_o` clears on the edge that ends the one-cycle software ready pulse, without any further request.
- R9: A pin request has priority. A software strobe that arrives during a pin transaction stays pending and does not disturb `rdy_o`. After the pin request drops, `rdy_o` falls, and the software ready pulse follows W+5 edges after the drop.
- R10: A `wait_ld_i` pulse loads `wait_val_i` into the wait interval register. A value of 0 gives the minimum software latency of 3 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | 1 | Asynchronous frequency-shift request pin |
| hw_en_i | input | 1 | Configuration bit enabling the request pin path |
| stpclk_i | input | 1 | Asynchronous stop-clock request, always enabled |
| sw_set_i | input | 1 | Write strobe that arms the software request bit |
| wait_ld_i | input | 1 | Write strobe for the wait interval register |
| wait_val_i | input | WAIT_W | Wait interval value in clock cycles |
| quiet_i | input | 1 | Core quiescent with no bus cycle outstanding |
| rdy_o | output | 1 | Frequency may be changed now |
| sw_pend_o | output | 1 | Software request bit, cleared by the block when it completes |

## Verification
The bench measures exact edge counts for ready rising and falling on each path. An extra or missing synchronizer stage, or a missed quiescence wait, therefore shows up as a wrong latency and not merely as a late pass. It holds `quiet_i` low while a request waits, to catch a design that raises ready at an unsafe point. It drives the request pin with the enable clear, to catch a design that leaks an ignored request or turns it into a software request. It arms a software request in the middle of a pin transaction. A design with the wrong priority would cut ready short there, and one that forgets the pending bit would never deliver the software pulse. It also loads a zero wait value to expose off-by-one errors in the down-counter.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HW_WQ  = 3'd1,
    ST_HW_RDY = 3'd2,
    ST_SW_CNT = 3'd3,
    ST_SW_RDY = 3'd4
  } fs_state_e;
endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain_q [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[b] <= '0;
      else if (STAGES == 1) chain_q[b] <= d_i[b];
      else chain_q[b] <= {chain_q[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[b][STAGES-1];
  end
endmodule

// File: rtl/fs_wait_timer.sv
module fs_wait_timer #(
  parameter int unsigned          WAIT_W   = 8,
  parameter logic [WAIT_W-1:0]    DEF_WAIT = WAIT_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [WAIT_W-1:0] val_i,
  input  logic              start_i,
  input  logic              run_i,
  output logic              zero_o
);
  logic [WAIT_W-1:0] cfg_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= DEF_WAIT;
    else if (ld_i) cfg_q <= val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= cfg_q;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fs_ctrl_fsm.sv
module fs_ctrl_fsm
  import fs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pin_req_i,
  input  logic      sw_set_i,
  input  logic      quiet_i,
  input  logic      tmr_zero_i,
  output logic      tmr_start_o,
  output logic      tmr_run_o,
  output logic      rdy_o,
  output logic      sw_pend_o,
  output fs_state_e state_o
);
  fs_state_e state_q, state_d;
  logic      pend_q;

  always_comb begin
    state_d     = state_q;
    tmr_start_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pin_req_i) state_d = ST_HW_WQ;
        else if (pend_q) begin
          state_d     = ST_SW_CNT;
          tmr_start_o = 1'b1;
        end
      end
      ST_HW_WQ: begin
        if (!pin_req_i) state_d = ST_IDLE;
        else if (quiet_i) state_d = ST_HW_RDY;
      end
      ST_HW_RDY: if (!pin_req_i) state_d = ST_IDLE;
      ST_SW_CNT: if (tmr_zero_i && quiet_i) state_d = ST_SW_RDY;
      ST_SW_RDY: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  // set wins only outside the completing cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (state_q == ST_SW_RDY) pend_q <= 1'b0;
    else if (sw_set_i) pend_q <= 1'b1;
  end

  assign tmr_run_o = (state_q == ST_SW_CNT);
  assign rdy_o     = (state_q == ST_HW_RDY) || (state_q == ST_SW_RDY);
  assign sw_pend_o = pend_q;
  assign state_o   = state_q;
endmodule

// File: rtl/freq_shift_ctrl.sv
module freq_shift_ctrl
  import fs_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       WAIT_W      = 8,
  parameter logic [WAIT_W-1:0] DEF_WAIT    = WAIT_W'(4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_req_i,
  input  logic              hw_en_i,
  input  logic              stpclk_i,
  input  logic              sw_set_i,
  input  logic              wait_ld_i,
  input  logic [WAIT_W-1:0] wait_val_i,
  input  logic              quiet_i,
  output logic              rdy_o,
  output logic              sw_pend_o
);
  localparam int unsigned NUM_PINS = 2;

  logic [NUM_PINS-1:0] pin_raw, pin_sync;
  logic                pin_req, tmr_start, tmr_run, tmr_zero;
  fs_state_e           state;

  assign pin_raw = {stpclk_i, hw_req_i};

  fs_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_sync)
  );

  assign pin_req = (pin_sync[0] && hw_en_i) || pin_sync[1];

  fs_wait_timer #(.WAIT_W(WAIT_W), .DEF_WAIT(DEF_WAIT)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (wait_ld_i),
    .val_i  (wait_val_i),
    .start_i(tmr_start),
    .run_i  (tmr_run),
    .zero_o (tmr_zero)
  );

  fs_ctrl_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_req_i  (pin_req),
    .sw_set_i   (sw_set_i),
    .quiet_i    (quiet_i),
    .tmr_zero_i (tmr_zero),
    .tmr_start_o(tmr_start),
    .tmr_run_o  (tmr_run),
    .rdy_o      (rdy_o),
    .sw_pend_o  (sw_pend_o),
    .state_o    (state)
  );
endmodule

// File: rtl/freq_shift_ctrl_chk.sv
module freq_shift_ctrl_chk
  import fs_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      quiet_i,
  input logic      rdy_o,
  input logic      sw_pend_o,
  input logic      pin_req,
  input logic      tmr_zero,
  input fs_state_e state
);
  a_r3_rdy_needs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(quiet_i));

  a_r4_hold_while_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HW_RDY && pin_req) |=> rdy_o);

  a_r5_no_rdy_without_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && !pin_req && !sw_pend_o) |=> !rdy_o);

  a_r7_sw_ready_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SW_RDY) |=> !rdy_o);

  a_r7_sw_ready_after_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SW_RDY) |-> $past(tmr_zero));

  a_r8_pend_self_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SW_RDY) |=> !sw_pend_o);
endmodule

bind freq_shift_ctrl freq_shift_ctrl_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .quiet_i  (quiet_i),
  .rdy_o    (rdy_o),
  .sw_pend_o(sw_pend_o),
  .pin_req  (pin_req),
  .tmr_zero (tmr_zero),
  .state    (state)
);

// File: tb/test_freq_shift_ctrl.sv
`timescale 1ns/1ps
module test_freq_shift_ctrl;
  localparam int SYNC = 2;
  localparam int WW   = 8;
  localparam int DEFW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hw_req = 0, hw_en = 0, stpclk = 0, sw_set = 0, wait_ld = 0, quiet = 1;
  logic [WW-1:0] wait_val = '0;
  logic rdy, sw_pend;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  freq_shift_ctrl #(.SYNC_STAGES(SYNC), .WAIT_W(WW), .DEF_WAIT(WW'(DEFW))) i_freq_shift_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw_req), .hw_en_i(hw_en),
    .stpclk_i(stpclk), .sw_set_i(sw_set), .wait_ld_i(wait_ld),
    .wait_val_i(wait_val), .quiet_i(quiet), .rdy_o(rdy), .sw_pend_o(sw_pend)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // negedges until rdy equals lvl, capped
  task automatic count_to(input logic lvl, input int cap, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (rdy !== lvl && k < cap);
  endtask

  task automatic sw_strobe();
    sw_set = 1; @(negedge clk); sw_set = 0;
  endtask

  task automatic t_reset();
    check(rdy === 1'b0, "R1 rdy", rdy, 0);
    check(sw_pend === 1'b0, "R1 sw_pend", sw_pend, 0);
  endtask

  task automatic t_hw_basic();
    int k;
    hw_en = 1; quiet = 1; hw_req = 1;
    count_to(1'b1, 30, k);
    check(k == SYNC + 2, "R2 rise latency", k, SYNC + 2);
    repeat (6) @(negedge clk);
    check(rdy === 1'b1, "R4 held", rdy, 1);
    hw_req = 0;
    count_to(1'b0, 30, k);
    check(k == SYNC + 1, "R4 fall latency", k, SYNC + 1);
    @(negedge clk);
  endtask

  task automatic t_quiet_wait();
    int k;
    hw_en = 1; quiet = 0; hw_req = 1;
    repeat (12) @(negedge clk);
    check(rdy === 1'b0, "R3 no rdy while busy", rdy, 0);
    quiet = 1;
    count_to(1'b1, 30, k);
    check(k == 1, "R3 rise after quiet", k, 1);
    hw_req = 0;
    count_to(1'b0, 30, k);
    check(k == SYNC + 1, "R4 fall after quiet test", k, SYNC + 1);
    @(negedge clk);
  endtask

  task automatic t_disabled();
    int hits = 0;
    hw_en = 0; quiet = 1; hw_req = 1;
    repeat (20) begin
      @(negedge clk);
      if (rdy !== 1'b0) hits++;
    end
    check(hits == 0, "R5 rdy while disabled", hits, 0);
    check(sw_pend === 1'b0, "R5 no sw request", sw_pend, 0);
    hw_req = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_stpclk();
    int k;
    hw_en = 0; quiet = 1; stpclk = 1;
    count_to(1'b1, 30, k);
    check(k == SYNC + 2, "R6 stpclk rise", k, SYNC + 2);
    stpclk = 0;
    count_to(1'b0, 30, k);
    check(k == SYNC + 1, "R6 stpclk fall", k, SYNC + 1);
    @(negedge clk);
  endtask

  task automatic t_sw(input int w, input string req);
    int k;
    quiet = 1;
    sw_set = 1;
    count_to(1'b1, 300, k);
    sw_set = 0;
    check(k == w + 3, req, k, w + 3);
    @(negedge clk);
    check(rdy === 1'b0, "R7 one-cycle pulse", rdy, 0);
    check(sw_pend === 1'b0, "R8 pend self-clear", sw_pend, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_sw_pend_visible();
    sw_strobe();
    check(sw_pend === 1'b1, "R7 pend set", sw_pend, 1);
    repeat (DEFW + 4) @(negedge clk);
    check(sw_pend === 1'b0, "R8 pend cleared later", sw_pend, 0);
  endtask

  task automatic t_load(input int v);
    wait_val = WW'(v); wait_ld = 1; @(negedge clk); wait_ld = 0;
  endtask

  task automatic t_priority(input int w);
    int k;
    hw_en = 1; quiet = 1; hw_req = 1;
    count_to(1'b1, 30, k);
    check(k == SYNC + 2, "R9 hw rise", k, SYNC + 2);
    sw_strobe();
    repeat (5) @(negedge clk);
    check(rdy === 1'b1, "R9 hw rdy kept", rdy, 1);
    check(sw_pend === 1'b1, "R9 sw still pending", sw_pend, 1);
    hw_req = 0;
    count_to(1'b0, 30, k);
    check(k == SYNC + 1, "R9 hw fall", k, SYNC + 1);
    begin
      int k2;
      count_to(1'b1, 300, k2);
      check(k + k2 == w + 5, "R9 sw after hw", k + k2, w + 5);
    end
    @(negedge clk);
    check(sw_pend === 1'b0, "R9 pend cleared", sw_pend, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_hw_basic();
    t_quiet_wait();
    t_disabled();
    t_stpclk();
    t_sw(DEFW, "R1 R7 default wait latency");
    t_sw_pend_visible();
    t_load(0);
    t_sw(0, "R10 zero wait latency");
    t_load(9);
    t_sw(9, "R10 loaded wait latency");
    t_priority(9);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule